// File: doc/BRIEF.md
# Dual-Mode Pipelined Residue Multiplier

This block is the multiply stage of one channel of a residue-number arithmetic unit. Each issued operation picks one of two modes. In wide mode it forms one full 35x35-bit unsigned product. In pair mode it forms two independent 35x25-bit unsigned products in the same slot. Pair mode serves base extension. That step consists mostly of multiplications by precomputed constants, and those constants fit in 25 bits when the bases are chosen suitably. Two constant products per issue slot cut the cycle count of a reduction from about 2n+3 to about n+4 for n channels.

The hardware has two 35x25-bit lane multipliers. In wide mode both lanes receive the same first operand. One lane takes the low 25 bits of the second operand and the other takes its 10 high bits. A later stage shifts the two partial products into place and adds them. The mode bit travels down the pipeline as a tag next to the data, so wide and pair operations can follow each other on consecutive cycles with no gap. Every operation takes exactly four register stages, and a new operation can be issued every cycle.

Top module: `dual_mode_residue_mult`

## Requirements
- R1: With valid_i high and mode_i = 0 (wide), wide_o carries the unsigned 70-bit product op_a_i * op_b_i when that operation leaves the pipeline.
- R2: With valid_i high and mode_i = 1 (pair), pair0_o carries op_a_i * const0_i and pair1_o carries op_c_i * const1_i, both unsigned and 60 bits wide.
- R3: valid_o goes high after the fourth rising edge, counting the edge that samples valid_i, and the block accepts a new operation on every cycle.
- R4: mode_o repeats the mode of the operation whose result is on the outputs, and operations of alternating modes on consecutive cycles each return correct results with no gap.
- R5: For a wide result pair0_o and pair1_o are zero. For a pair result wide_o is zero.
- R6: In wide mode op_c_i, const0_i and const1_i have no effect on the result. In pair mode op_b_i has no effect on the result.
- R7: While valid_o is low, wide_o, pair0_o and pair1_o are all zero. Operands presented with valid_i low produce no output.
- R8: Asserting rst_ni low clears valid_o, mode_o and all data outputs at once and discards every operation still in flight.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Issue an operation this cycle |
| mode_i | input | 1 | 0 selects the wide product, 1 selects the pair of constant products |
| op_a_i | input | 35 | First operand in both modes |
| op_b_i | input | 35 | Second operand of the wide product |
| op_c_i | input | 35 | Operand of the second pair product |
| const0_i | input | 25 | Constant of the first pair product |
| const1_i | input | 25 | Constant of the second pair product |
| valid_o | output | 1 | A result is present |
| mode_o | output | 1 | Mode tag of the present result |
| wide_o | output | 70 | Wide-mode product |
| pair0_o | output | 60 | First pair-mode product |
| pair1_o | output | 60 | Second pair-mode product |

## Verification
The hardest case to reach is a wide operation directly after a pair operation, or the reverse. In that case the lanes carry one operation's operand routing while the merge stage still holds the other operation's tag. Only a back-to-back stream of mixed modes shows whether the tag stays attached to the correct data. The bench therefore streams alternating and randomly mixed modes with no idle cycles between them, and also puts the largest operands through both modes. The largest operands make the shifted high partial product carry into the top bits of wide_o.

// File: rtl/dmm_pkg.sv
package dmm_pkg;
  typedef enum logic {
    MODE_WIDE = 1'b0,
    MODE_PAIR = 1'b1
  } dmm_mode_e;

  localparam int unsigned LANES = 2;
endpackage

// File: rtl/dmm_route.sv
// Stage 1: steer operands onto the two lane multipliers.
module dmm_route #(
  parameter int unsigned OP_W = 35,
  parameter int unsigned K_W  = 25
) (
  input  logic                                     clk_i,
  input  logic                                     rst_ni,
  input  logic                                     valid_i,
  input  logic                                     mode_i,
  input  logic [OP_W-1:0]                          op_a_i,
  input  logic [OP_W-1:0]                          op_b_i,
  input  logic [OP_W-1:0]                          op_c_i,
  input  logic [K_W-1:0]                           const0_i,
  input  logic [K_W-1:0]                           const1_i,
  output logic [dmm_pkg::LANES-1:0][OP_W-1:0]      x_o,
  output logic [dmm_pkg::LANES-1:0][K_W-1:0]       y_o,
  output logic                                     mode_o,
  output logic                                     valid_o
);
  import dmm_pkg::*;
  localparam int unsigned HI_W = OP_W - K_W;  // requires K_W >= HI_W

  logic [LANES-1:0][OP_W-1:0] x_d;
  logic [LANES-1:0][K_W-1:0]  y_d;

  always_comb begin
    x_d = '0;
    y_d = '0;
    if (valid_i) begin
      if (dmm_mode_e'(mode_i) == MODE_PAIR) begin
        x_d[0] = op_a_i;
        y_d[0] = const0_i;
        x_d[1] = op_c_i;
        y_d[1] = const1_i;
      end else begin
        x_d[0] = op_a_i;
        y_d[0] = op_b_i[K_W-1:0];
        x_d[1] = op_a_i;
        y_d[1] = {{(K_W-HI_W){1'b0}}, op_b_i[OP_W-1:K_W]};
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      x_o     <= '0;
      y_o     <= '0;
      mode_o  <= 1'b0;
      valid_o <= 1'b0;
    end else begin
      x_o     <= x_d;
      y_o     <= y_d;
      mode_o  <= valid_i & mode_i;
      valid_o <= valid_i;
    end
  end
endmodule

// File: rtl/dmm_lane.sv
// Stage 2: one registered OP_W x K_W unsigned multiplier.
module dmm_lane #(
  parameter int unsigned OP_W = 35,
  parameter int unsigned K_W  = 25
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic [OP_W-1:0]       x_i,
  input  logic [K_W-1:0]        y_i,
  output logic [OP_W+K_W-1:0]   p_o
);
  localparam int unsigned NP_W = OP_W + K_W;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) p_o <= '0;
    else         p_o <= NP_W'(x_i) * NP_W'(y_i);
  end
endmodule

// File: rtl/dmm_merge.sv
// Stage 3: align and add wide partials. Stage 4: mode-gated outputs.
module dmm_merge #(
  parameter int unsigned OP_W = 35,
  parameter int unsigned K_W  = 25
) (
  input  logic                                   clk_i,
  input  logic                                   rst_ni,
  input  logic [dmm_pkg::LANES-1:0][OP_W+K_W-1:0] p_i,
  input  logic                                   mode_i,
  input  logic                                   valid_i,
  output logic                                   valid_o,
  output logic                                   mode_o,
  output logic [2*OP_W-1:0]                      wide_o,
  output logic [OP_W+K_W-1:0]                    pair0_o,
  output logic [OP_W+K_W-1:0]                    pair1_o
);
  import dmm_pkg::*;
  localparam int unsigned NP_W   = OP_W + K_W;
  localparam int unsigned PROD_W = 2 * OP_W;
  localparam int unsigned EXT_W  = PROD_W - NP_W;

  logic [PROD_W-1:0] sum_d, sum_q;
  logic [NP_W-1:0]   n0_q, n1_q;
  logic              mode_q, valid_q;

  assign sum_d = {{EXT_W{1'b0}}, p_i[0]} + ({{EXT_W{1'b0}}, p_i[1]} << K_W);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sum_q   <= '0;
      n0_q    <= '0;
      n1_q    <= '0;
      mode_q  <= 1'b0;
      valid_q <= 1'b0;
    end else begin
      sum_q   <= sum_d;
      n0_q    <= p_i[0];
      n1_q    <= p_i[1];
      mode_q  <= mode_i;
      valid_q <= valid_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o <= 1'b0;
      mode_o  <= 1'b0;
      wide_o  <= '0;
      pair0_o <= '0;
      pair1_o <= '0;
    end else begin
      valid_o <= valid_q;
      mode_o  <= valid_q & mode_q;
      wide_o  <= (valid_q && dmm_mode_e'(mode_q) == MODE_WIDE) ? sum_q : '0;
      pair0_o <= (valid_q && dmm_mode_e'(mode_q) == MODE_PAIR) ? n0_q : '0;
      pair1_o <= (valid_q && dmm_mode_e'(mode_q) == MODE_PAIR) ? n1_q : '0;
    end
  end
endmodule

// File: rtl/dual_mode_residue_mult.sv
module dual_mode_residue_mult #(
  parameter int unsigned OP_W = 35,
  parameter int unsigned K_W  = 25
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   valid_i,
  input  logic                   mode_i,
  input  logic [OP_W-1:0]        op_a_i,
  input  logic [OP_W-1:0]        op_b_i,
  input  logic [OP_W-1:0]        op_c_i,
  input  logic [K_W-1:0]         const0_i,
  input  logic [K_W-1:0]         const1_i,
  output logic                   valid_o,
  output logic                   mode_o,
  output logic [2*OP_W-1:0]      wide_o,
  output logic [OP_W+K_W-1:0]    pair0_o,
  output logic [OP_W+K_W-1:0]    pair1_o
);
  import dmm_pkg::*;
  localparam int unsigned NP_W = OP_W + K_W;

  logic [LANES-1:0][OP_W-1:0] s1_x;
  logic [LANES-1:0][K_W-1:0]  s1_y;
  logic                       s1_mode, s1_valid;
  logic [LANES-1:0][NP_W-1:0] s2_p;
  logic                       s2_mode, s2_valid;

  dmm_route #(.OP_W(OP_W), .K_W(K_W)) u_route (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .valid_i  (valid_i),
    .mode_i   (mode_i),
    .op_a_i   (op_a_i),
    .op_b_i   (op_b_i),
    .op_c_i   (op_c_i),
    .const0_i (const0_i),
    .const1_i (const1_i),
    .x_o      (s1_x),
    .y_o      (s1_y),
    .mode_o   (s1_mode),
    .valid_o  (s1_valid)
  );

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    dmm_lane #(.OP_W(OP_W), .K_W(K_W)) u_lane (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .x_i    (s1_x[g]),
      .y_i    (s1_y[g]),
      .p_o    (s2_p[g])
    );
  end

  // mode tag rides alongside the lane registers
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s2_mode  <= 1'b0;
      s2_valid <= 1'b0;
    end else begin
      s2_mode  <= s1_mode;
      s2_valid <= s1_valid;
    end
  end

  dmm_merge #(.OP_W(OP_W), .K_W(K_W)) u_merge (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .p_i     (s2_p),
    .mode_i  (s2_mode),
    .valid_i (s2_valid),
    .valid_o (valid_o),
    .mode_o  (mode_o),
    .wide_o  (wide_o),
    .pair0_o (pair0_o),
    .pair1_o (pair1_o)
  );
endmodule

// File: rtl/dmm_checker.sv
module dmm_checker #(
  parameter int unsigned OP_W = 35,
  parameter int unsigned K_W  = 25
) (
  input logic                clk_i,
  input logic                rst_ni,
  input logic                valid_i,
  input logic                mode_i,
  input logic [OP_W-1:0]     op_a_i,
  input logic [OP_W-1:0]     op_b_i,
  input logic [OP_W-1:0]     op_c_i,
  input logic [K_W-1:0]      const0_i,
  input logic [K_W-1:0]      const1_i,
  input logic                valid_o,
  input logic                mode_o,
  input logic [2*OP_W-1:0]   wide_o,
  input logic [OP_W+K_W-1:0] pair0_o,
  input logic [OP_W+K_W-1:0] pair1_o
);
  localparam int unsigned NP_W   = OP_W + K_W;
  localparam int unsigned PROD_W = 2 * OP_W;

  logic [2:0] since_rst;
  logic       aged;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)             since_rst <= '0;
    else if (since_rst != 4) since_rst <= since_rst + 3'd1;
  end
  assign aged = (since_rst == 3'd4);

  AST_VALID_LATENCY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    aged |-> (valid_o == $past(valid_i, 4)));  // R3

  AST_MODE_TAG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (aged && valid_o) |-> (mode_o == $past(mode_i, 4)));  // R4

  AST_WIDE_PRODUCT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (aged && valid_o && !mode_o) |->
      (wide_o == PROD_W'($past(op_a_i, 4)) * PROD_W'($past(op_b_i, 4))));  // R1

  AST_PAIR_PRODUCTS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (aged && valid_o && mode_o) |->
      ((pair0_o == NP_W'($past(op_a_i, 4)) * NP_W'($past(const0_i, 4))) &&
       (pair1_o == NP_W'($past(op_c_i, 4)) * NP_W'($past(const1_i, 4)))));  // R2

  AST_INACTIVE_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> (mode_o ? (wide_o == '0) : (pair0_o == '0 && pair1_o == '0)));  // R5

  AST_IDLE_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_o |-> (wide_o == '0 && pair0_o == '0 && pair1_o == '0 && !mode_o));  // R7

  always_ff @(posedge clk_i) begin
    if (!rst_ni) begin
      AST_RESET_CLEAR: assert (!valid_o && !mode_o && wide_o == '0) else $error("reset clear");  // R8
    end
  end
endmodule

bind dual_mode_residue_mult dmm_checker #(.OP_W(OP_W), .K_W(K_W)) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .valid_i  (valid_i),
  .mode_i   (mode_i),
  .op_a_i   (op_a_i),
  .op_b_i   (op_b_i),
  .op_c_i   (op_c_i),
  .const0_i (const0_i),
  .const1_i (const1_i),
  .valid_o  (valid_o),
  .mode_o   (mode_o),
  .wide_o   (wide_o),
  .pair0_o  (pair0_o),
  .pair1_o  (pair1_o)
);

// File: tb/dual_mode_residue_mult_tb.sv
`timescale 1ns/1ps
module dual_mode_residue_mult_tb;
  localparam int OP_W = 35;
  localparam int K_W  = 25;
  localparam int NP_W = OP_W + K_W;
  localparam int PW   = 2 * OP_W;
  localparam int MAXS = 64;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic valid_i = 1'b0, mode_i = 1'b0;
  logic [OP_W-1:0] op_a_i = '0, op_b_i = '0, op_c_i = '0;
  logic [K_W-1:0]  const0_i = '0, const1_i = '0;
  logic valid_o, mode_o;
  logic [PW-1:0]   wide_o;
  logic [NP_W-1:0] pair0_o, pair1_o;

  int n_checks = 0;
  int n_err = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  dual_mode_residue_mult #(.OP_W(OP_W), .K_W(K_W)) u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .valid_i(valid_i), .mode_i(mode_i),
    .op_a_i(op_a_i), .op_b_i(op_b_i), .op_c_i(op_c_i),
    .const0_i(const0_i), .const1_i(const1_i),
    .valid_o(valid_o), .mode_o(mode_o), .wide_o(wide_o),
    .pair0_o(pair0_o), .pair1_o(pair1_o)
  );

  // stream slots
  logic            s_v  [MAXS];
  logic            s_m  [MAXS];
  logic [OP_W-1:0] s_a  [MAXS];
  logic [OP_W-1:0] s_b  [MAXS];
  logic [OP_W-1:0] s_c  [MAXS];
  logic [K_W-1:0]  s_k0 [MAXS];
  logic [K_W-1:0]  s_k1 [MAXS];

  task automatic chk(input bit ok, input string req, input logic [127:0] act, input logic [127:0] exp);
    n_checks++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [OP_W-1:0] rnd_op();
    return {$urandom, $urandom};
  endfunction

  task automatic drive_slot(input int i);
    valid_i  = s_v[i];
    mode_i   = s_m[i];
    op_a_i   = s_a[i];
    op_b_i   = s_b[i];
    op_c_i   = s_c[i];
    const0_i = s_k0[i];
    const1_i = s_k1[i];
  endtask

  task automatic check_slot(input int i, input string tag);
    logic [PW-1:0]   ew;
    logic [NP_W-1:0] e0, e1;
    ew = (s_v[i] && !s_m[i]) ? PW'(s_a[i]) * PW'(s_b[i]) : '0;
    e0 = (s_v[i] && s_m[i]) ? NP_W'(s_a[i]) * NP_W'(s_k0[i]) : '0;
    e1 = (s_v[i] && s_m[i]) ? NP_W'(s_c[i]) * NP_W'(s_k1[i]) : '0;
    chk(valid_o == s_v[i], {"R3 valid ", tag}, 128'(valid_o), 128'(s_v[i]));
    chk(mode_o == (s_v[i] & s_m[i]), {"R4 mode tag ", tag}, 128'(mode_o), 128'(s_v[i] & s_m[i]));
    chk(wide_o == ew, {"R1/R5/R7 wide ", tag}, 128'(wide_o), 128'(ew));
    chk(pair0_o == e0, {"R2/R5/R7 pair0 ", tag}, 128'(pair0_o), 128'(e0));
    chk(pair1_o == e1, {"R2/R5/R7 pair1 ", tag}, 128'(pair1_o), 128'(e1));
  endtask

  // slot i driven before edge i, observed 4 negedges later
  task automatic run_stream(input int n, input string tag);
    for (int i = 0; i < n + 4; i++) begin
      @(negedge clk);
      if (i >= 4) check_slot(i - 4, tag);
      if (i < n) drive_slot(i);
      else valid_i = 1'b0;
    end
  endtask

  task automatic fill_rand(input int i, input logic v, input logic m);
    s_v[i] = v; s_m[i] = m;
    s_a[i] = rnd_op(); s_b[i] = rnd_op(); s_c[i] = rnd_op();
    s_k0[i] = K_W'($urandom); s_k1[i] = K_W'($urandom);
  endtask

  task automatic t_reset();
    #1;
    chk(valid_o == 1'b0 && mode_o == 1'b0, "R8 reset valid/mode", 128'({valid_o, mode_o}), 128'(0));
    chk(wide_o == '0 && pair0_o == '0 && pair1_o == '0, "R8 reset data", 128'(wide_o), 128'(0));
    repeat (2) @(negedge clk);
    rst_ni = 1'b1;
  endtask

  task automatic t_latency();
    @(negedge clk);
    valid_i = 1'b1; mode_i = 1'b0; op_a_i = 35'd7; op_b_i = 35'd9;
    @(negedge clk);
    valid_i = 1'b0; op_a_i = '0; op_b_i = '0;
    for (int k = 1; k < 4; k++) begin
      chk(valid_o == 1'b0, "R3 early valid", 128'(valid_o), 128'(0));
      @(negedge clk);
    end
    chk(valid_o == 1'b1, "R3 valid at fourth edge", 128'(valid_o), 128'(1));
    chk(wide_o == 70'd63, "R1 small product", 128'(wide_o), 128'(63));
    @(negedge clk);
    chk(valid_o == 1'b0, "R3 single result", 128'(valid_o), 128'(0));
  endtask

  task automatic t_corners();
    for (int i = 0; i < 6; i++) fill_rand(i, 1'b1, i[0]);
    s_a[0] = '1; s_b[0] = '1;                     // R1 carry into top bits
    s_a[1] = '1; s_k0[1] = '1; s_c[1] = '1; s_k1[1] = '1;  // R2 max constants
    s_a[2] = '0; s_b[2] = '1;
    s_a[3] = 35'd1; s_k0[3] = '1; s_c[3] = '1; s_k1[3] = 25'd1;
    s_a[4] = 35'h4_0000_0000; s_b[4] = 35'h2_0000_0000;
    s_a[5] = '1; s_k0[5] = '0; s_c[5] = '0; s_k1[5] = '1;
    run_stream(6, "corners");
  endtask

  // R6: unused inputs carry noise; expected values ignore them
  task automatic t_ignored();
    for (int i = 0; i < 8; i++) fill_rand(i, 1'b1, i[0]);
    run_stream(8, "R6 unused-inputs noise");
    for (int i = 0; i < 4; i++) begin
      fill_rand(2*i, 1'b1, 1'b0); fill_rand(2*i+1, 1'b1, 1'b0);
      s_a[2*i+1] = s_a[2*i]; s_b[2*i+1] = s_b[2*i];
      s_c[2*i+1] = ~s_c[2*i]; s_k0[2*i+1] = ~s_k0[2*i]; s_k1[2*i+1] = ~s_k1[2*i];
    end
    run_stream(8, "R6 wide ignores c/k");
  endtask

  task automatic t_streams();
    for (int i = 0; i < 40; i++) fill_rand(i, 1'b1, 1'b0);
    run_stream(40, "wide stream");
    for (int i = 0; i < 40; i++) fill_rand(i, 1'b1, 1'b1);
    run_stream(40, "pair stream");
    for (int i = 0; i < 40; i++) fill_rand(i, 1'b1, i[0]);
    run_stream(40, "R4 alternating");
    for (int i = 0; i < 60; i++) fill_rand(i, ($urandom % 4) != 0, $urandom % 2);
    run_stream(60, "R7 mixed with idle");
  endtask

  task automatic t_reset_flush();
    for (int i = 0; i < 3; i++) fill_rand(i, 1'b1, i[0]);
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      drive_slot(i);
    end
    @(negedge clk);
    valid_i = 1'b0;
    rst_ni = 1'b0;
    #1;
    chk(valid_o == 1'b0 && wide_o == '0 && pair0_o == '0, "R8 async clear", 128'(valid_o), 128'(0));
    @(negedge clk);
    rst_ni = 1'b1;
    for (int k = 0; k < 5; k++) begin
      @(negedge clk);
      chk(valid_o == 1'b0, "R8 in-flight discarded", 128'(valid_o), 128'(0));
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_err++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_latency();
    t_corners();
    t_ignored();
    t_streams();
    t_reset_flush();
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
    $finish;
  end
endmodule